// File: doc/BRIEF.md
# Remote Request Tracking Buffer

This block sits beside a node's shared bus, which cannot split transactions, and keeps a small table of processor accesses that must be served by another node. When a local processor issues an access that has to go off-node, the block refuses the access with a retry, claims a free slot, and emits one request towards the line's home node, tagged with the slot index. The processor then keeps retrying. Until the home reply arrives each retry is refused again. Once the reply arrives, the block raises a wake pulse so the bus can re-arbitrate the processor, and the next retry is answered with the buffered line data. From the processor's side this behaves like a split transaction.

For ownership (read-exclusive) requests, the home reply also says how many invalidations it sent to other sharers. The remote sharers then acknowledge one by one. The slot keeps a signed running balance: each acknowledgement subtracts one, and the reply adds its count, so acknowledgements that overtake the reply are handled. An ownership slot is released only after the data has been consumed and the balance is back at zero. A plain read slot is released as soon as its data is consumed.

Top module: `remote_req_tracker`

## Requirements
- R1: After reset every slot is free and all outputs are low. A reset applied later discards all tracked requests, so the next remote access is given slot 0.
- R2: An access to a line that no slot tracks gets a response one cycle later with retry set. In the same cycle, a network request appears carrying the access's address, its exclusive flag and the claimed slot index as tag.
- R3: An access to a line whose slot is still waiting for its reply is answered with retry, and no network request is sent.
- R4: A reply for a waiting slot produces, one cycle later, a single-cycle wake pulse that carries the slot index.
- R5: After the reply, the next access to that line is answered one cycle later with retry clear and the reply's data.
- R6: For a plain read slot, the invalidation count field of the reply is ignored. The slot becomes free in the same cycle that its data is consumed.
- R7: For an exclusive slot, the reply adds its count to the balance and each acknowledgement carrying that slot's tag subtracts one. The slot becomes free once the data has been consumed and the balance is zero.
- R8: After an exclusive slot's data has been consumed, and while its balance is not zero, an access to that line is answered with retry and no network request is sent.
- R9: An acknowledgement that arrives before its slot's reply drives the balance negative. The reply's count later brings it back to zero.
- R10: When every slot is busy, an access to an untracked line is answered with retry and no network request is sent. Once a slot frees, the same access is accepted.
- R11: A new request always claims the free slot with the lowest index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor presents an off-node access this cycle |
| cpu_req_excl | input | 1 | Access needs ownership (read-exclusive) |
| cpu_req_addr | input | AW | Line address of the access |
| cpu_rsp_valid | output | 1 | Response to the access of the previous cycle |
| cpu_rsp_retry | output | 1 | Access refused; processor must retry |
| cpu_rsp_data | output | DW | Line data when retry is clear |
| cpu_wake | output | 1 | Pulse: a reply has arrived, processor may retry |
| cpu_wake_tag | output | TW | Slot whose reply arrived |
| net_req_valid | output | 1 | Request to the home node |
| net_req_excl | output | 1 | Request asks for ownership |
| net_req_addr | output | AW | Line address of the request |
| net_req_tag | output | TW | Slot index carried by the request |
| rep_valid | input | 1 | Home reply arrives |
| rep_tag | input | TW | Slot the reply belongs to |
| rep_data | input | DW | Line data |
| rep_inv_cnt | input | CW | Invalidations sent by home (ownership replies only) |
| ack_valid | input | 1 | Invalidation acknowledgement arrives |
| ack_tag | input | TW | Slot the acknowledgement belongs to |

## Verification
The stimulus mixes plain reads with ownership requests. In one ownership case an acknowledgement overtakes the reply, which separates a signed balance from one that clamps at zero or ignores early acknowledgements. A read reply carries a non-zero count that must be ignored. Slot reuse is then observed through the tag of the next request, which shows whether that count leaked into the read slot. Retries aimed at a draining ownership slot, followed by a sequence that fills every slot, show that blocked and refused accesses send nothing. A reset in mid-run shows that all tracked state is discarded.

// File: rtl/rrt_pkg.sv
package rrt_pkg;

    // Life cycle of one tracking slot
    typedef enum logic [1:0] {
        SLOT_FREE  = 2'd0,  // unused
        SLOT_WAIT  = 2'd1,  // request sent, reply outstanding
        SLOT_READY = 2'd2,  // data buffered, not yet consumed
        SLOT_DRAIN = 2'd3   // data consumed, acknowledgements outstanding
    } slot_state_e;

endpackage

// File: rtl/rrt_lookup.sv
module rrt_lookup #(
    parameter int N  = 4,
    parameter int AW = 16,
    localparam int TW = (N > 1) ? $clog2(N) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N-1:0]          busy,
    input  logic [N-1:0][AW-1:0]  addrs,
    input  logic [AW-1:0]         key,
    output logic                  hit,
    output logic [TW-1:0]         hit_idx
);

    logic [N-1:0] match;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = busy[g] && (addrs[g] == key);
    end

    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (match[i] && !hit) begin
                hit     = 1'b1;
                hit_idx = TW'(i);
            end
        end
    end

    // R3: a line is tracked by at most one slot
    a_r3_single_owner_slot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

endmodule

// File: rtl/rrt_pick.sv
module rrt_pick #(
    parameter int N = 4,
    localparam int TW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  free,
    output logic          any,
    output logic [TW-1:0] idx
);

    logic [N-1:0] grant;
    logic [N-1:0] lower_free;

    // lower_free[i] is set when some slot below i is free
    assign lower_free[0] = 1'b0;
    for (genvar g = 1; g < N; g++) begin : g_chain
        assign lower_free[g] = lower_free[g-1] | free[g-1];
    end

    for (genvar g = 0; g < N; g++) begin : g_grant
        assign grant[g] = free[g] & ~lower_free[g];
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) idx = TW'(i);
        end
    end

    assign any = |free;

    // R11: at most one slot is granted
    a_r11_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R11: a grant exists whenever any slot is free
    a_r11_grant_when_free: assert property (@(posedge clk) disable iff (!rst_n)
        (|free) |-> (|grant));

endmodule

// File: rtl/remote_req_tracker.sv
module remote_req_tracker #(
    parameter int ENTRIES = 4,
    parameter int AW      = 16,
    parameter int DW      = 32,
    parameter int CW      = 4,
    localparam int TW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_req_valid,
    input  logic          cpu_req_excl,
    input  logic [AW-1:0] cpu_req_addr,
    output logic          cpu_rsp_valid,
    output logic          cpu_rsp_retry,
    output logic [DW-1:0] cpu_rsp_data,
    output logic          cpu_wake,
    output logic [TW-1:0] cpu_wake_tag,
    output logic          net_req_valid,
    output logic          net_req_excl,
    output logic [AW-1:0] net_req_addr,
    output logic [TW-1:0] net_req_tag,
    input  logic          rep_valid,
    input  logic [TW-1:0] rep_tag,
    input  logic [DW-1:0] rep_data,
    input  logic [CW-1:0] rep_inv_cnt,
    input  logic          ack_valid,
    input  logic [TW-1:0] ack_tag
);
    import rrt_pkg::*;

    localparam int BW = CW + 1;  // signed balance width

    typedef struct packed {
        slot_state_e         st;
        logic                excl;
        logic [AW-1:0]       addr;
        logic [DW-1:0]       data;
        logic signed [BW-1:0] bal;
    } slot_t;

    typedef struct packed {
        slot_t [ENTRIES-1:0] slots;
        logic                rsp_valid;
        logic                rsp_retry;
        logic [DW-1:0]       rsp_data;
        logic                wake;
        logic [TW-1:0]       wake_tag;
        logic                net_valid;
        logic                net_excl;
        logic [AW-1:0]       net_addr;
        logic [TW-1:0]       net_tag;
    } state_t;

    state_t q, d;

    logic [ENTRIES-1:0]          busy_v;
    logic [ENTRIES-1:0]          free_v;
    logic [ENTRIES-1:0][AW-1:0]  addr_v;
    logic                        hit;
    logic [TW-1:0]               hit_idx;
    logic                        pick_any;
    logic [TW-1:0]               pick_idx;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_view
        assign busy_v[g] = (q.slots[g].st != SLOT_FREE);
        assign free_v[g] = (q.slots[g].st == SLOT_FREE);
        assign addr_v[g] = q.slots[g].addr;
    end

    rrt_lookup #(.N(ENTRIES), .AW(AW)) u_lookup (
        .clk     (clk),
        .rst_n   (rst_n),
        .busy    (busy_v),
        .addrs   (addr_v),
        .key     (cpu_req_addr),
        .hit     (hit),
        .hit_idx (hit_idx)
    );

    rrt_pick #(.N(ENTRIES)) u_pick (
        .clk   (clk),
        .rst_n (rst_n),
        .free  (free_v),
        .any   (pick_any),
        .idx   (pick_idx)
    );

    always_comb begin
        d           = q;
        d.rsp_valid = 1'b0;
        d.rsp_retry = 1'b0;
        d.wake      = 1'b0;
        d.net_valid = 1'b0;

        // replies and acknowledgements from the network
        for (int i = 0; i < ENTRIES; i++) begin
            if (rep_valid && rep_tag == TW'(i) && q.slots[i].st == SLOT_WAIT) begin
                d.slots[i].st   = SLOT_READY;
                d.slots[i].data = rep_data;
                if (q.slots[i].excl)
                    d.slots[i].bal = q.slots[i].bal + $signed({1'b0, rep_inv_cnt});
                d.wake     = 1'b1;
                d.wake_tag = rep_tag;
            end
            if (ack_valid && ack_tag == TW'(i) && q.slots[i].st != SLOT_FREE
                && q.slots[i].excl) begin
                d.slots[i].bal = d.slots[i].bal - BW'(1);
            end
        end

        // processor access, judged on the state at the start of the cycle
        if (cpu_req_valid) begin
            d.rsp_valid = 1'b1;
            d.rsp_retry = 1'b1;
            if (hit) begin
                for (int i = 0; i < ENTRIES; i++) begin
                    if (hit_idx == TW'(i) && q.slots[i].st == SLOT_READY) begin
                        d.rsp_retry   = 1'b0;
                        d.rsp_data    = q.slots[i].data;
                        d.slots[i].st = SLOT_DRAIN;
                    end
                end
            end else if (pick_any) begin
                for (int i = 0; i < ENTRIES; i++) begin
                    if (pick_idx == TW'(i)) begin
                        d.slots[i].st   = SLOT_WAIT;
                        d.slots[i].excl = cpu_req_excl;
                        d.slots[i].addr = cpu_req_addr;
                        d.slots[i].data = '0;
                        d.slots[i].bal  = '0;
                    end
                end
                d.net_valid = 1'b1;
                d.net_excl  = cpu_req_excl;
                d.net_addr  = cpu_req_addr;
                d.net_tag   = pick_idx;
            end
        end

        // release consumed slots whose balance has settled
        for (int i = 0; i < ENTRIES; i++) begin
            if (d.slots[i].st == SLOT_DRAIN && d.slots[i].bal == '0)
                d.slots[i].st = SLOT_FREE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cpu_rsp_valid = q.rsp_valid;
    assign cpu_rsp_retry = q.rsp_retry;
    assign cpu_rsp_data  = q.rsp_data;
    assign cpu_wake      = q.wake;
    assign cpu_wake_tag  = q.wake_tag;
    assign net_req_valid = q.net_valid;
    assign net_req_excl  = q.net_excl;
    assign net_req_addr  = q.net_addr;
    assign net_req_tag   = q.net_tag;

    // R2: every access is answered in the following cycle
    a_r2_access_answered: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req_valid |=> cpu_rsp_valid);

    // R2: a request leaves only together with a retry response
    a_r2_send_with_retry: assert property (@(posedge clk) disable iff (!rst_n)
        net_req_valid |-> (cpu_rsp_valid && cpu_rsp_retry));

    // R10: nothing is sent when no slot is free
    a_r10_full_no_send: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req_valid && !pick_any) |=> !net_req_valid);

    // R4: a wake pulse follows a reply
    a_r4_wake_after_reply: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wake |-> $past(rep_valid));

    // R8: a draining line neither supplies data nor sends a request
    a_r8_drain_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req_valid && hit && q.slots[hit_idx].st == SLOT_DRAIN)
        |=> (cpu_rsp_retry && !net_req_valid));

endmodule

// File: tb/remote_req_tracker_tb.sv
`timescale 1ns/1ps
module remote_req_tracker_tb;

    localparam int TW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_req_valid = 1'b0;
    logic          cpu_req_excl = 1'b0;
    logic [15:0]   cpu_req_addr = '0;
    logic          cpu_rsp_valid, cpu_rsp_retry;
    logic [31:0]   cpu_rsp_data;
    logic          cpu_wake;
    logic [TW-1:0] cpu_wake_tag;
    logic          net_req_valid, net_req_excl;
    logic [15:0]   net_req_addr;
    logic [TW-1:0] net_req_tag;
    logic          rep_valid = 1'b0;
    logic [TW-1:0] rep_tag = '0;
    logic [31:0]   rep_data = '0;
    logic [3:0]    rep_inv_cnt = '0;
    logic          ack_valid = 1'b0;
    logic [TW-1:0] ack_tag = '0;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    remote_req_tracker u_dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(cpu_req_valid), .cpu_req_excl(cpu_req_excl),
        .cpu_req_addr(cpu_req_addr),
        .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_retry(cpu_rsp_retry),
        .cpu_rsp_data(cpu_rsp_data),
        .cpu_wake(cpu_wake), .cpu_wake_tag(cpu_wake_tag),
        .net_req_valid(net_req_valid), .net_req_excl(net_req_excl),
        .net_req_addr(net_req_addr), .net_req_tag(net_req_tag),
        .rep_valid(rep_valid), .rep_tag(rep_tag), .rep_data(rep_data),
        .rep_inv_cnt(rep_inv_cnt),
        .ack_valid(ack_valid), .ack_tag(ack_tag)
    );

    // kind: 1 access, 2 reply, 3 acknowledgement
    typedef struct packed {
        logic [1:0]  kind;
        logic        excl;
        logic [15:0] addr;
        logic [1:0]  tag;
        logic [31:0] data;
        logic [3:0]  cnt;
        logic        e_rsp;
        logic        e_retry;
        logic [31:0] e_data;
        logic        e_net;
        logic [1:0]  e_tag;
        logic        e_wake;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{2'd1, 1'b0, 16'h0100, 2'd0, 32'h0,         4'd0, 1'b1, 1'b1, 32'h0,         1'b1, 2'd0, 1'b0, 8'd2},  // R2 read A -> slot 0
        '{2'd1, 1'b1, 16'h0200, 2'd0, 32'h0,         4'd0, 1'b1, 1'b1, 32'h0,         1'b1, 2'd1, 1'b0, 8'd2},  // R2 excl B -> slot 1
        '{2'd1, 1'b0, 16'h0100, 2'd0, 32'h0,         4'd0, 1'b1, 1'b1, 32'h0,         1'b0, 2'd0, 1'b0, 8'd3},  // R3 A still waiting
        '{2'd2, 1'b0, 16'h0000, 2'd0, 32'hAAAA0001, 4'd5, 1'b0, 1'b0, 32'h0,         1'b0, 2'd0, 1'b1, 8'd4},  // R4 reply A, stray count
        '{2'd1, 1'b0, 16'h0100, 2'd0, 32'h0,         4'd0, 1'b1, 1'b0, 32'hAAAA0001, 1'b0, 2'd0, 1'b0, 8'd5},  // R5 data A
        '{2'd1, 1'b0, 16'h0300, 2'd0, 32'h0,         4'd0, 1'b1, 1'b1, 32'h0,         1'b1, 2'd0, 1'b0, 8'd6},  // R6 slot 0 reused
        '{2'd3, 1'b0, 16'h0000, 2'd1, 32'h0,         4'd0, 1'b0, 1'b0, 32'h0,         1'b0, 2'd0, 1'b0, 8'd9},  // R9 early ack B
        '{2'd2, 1'b0, 16'h0000, 2'd1, 32'hBBBB0002, 4'd3, 1'b0, 1'b0, 32'h0,         1'b0, 2'd0, 1'b1, 8'd4},  // R4 reply B, count 3
        '{2'd1, 1'b1, 16'h0200, 2'd0, 32'h0,         4'd0, 1'b1, 1'b0, 32'hBBBB0002, 1'b0, 2'd0, 1'b0, 8'd5},  // R5 data B
        '{2'd1, 1'b1, 16'h0200, 2'd0, 32'h0,         4'd0, 1'b1, 1'b1, 32'h0,         1'b0, 2'd0, 1'b0, 8'd8},  // R8 B draining
        '{2'd3, 1'b0, 16'h0000, 2'd1, 32'h0,         4'd0, 1'b0, 1'b0, 32'h0,         1'b0, 2'd0, 1'b0, 8'd7},  // R7 ack B
        '{2'd1, 1'b1, 16'h0200, 2'd0, 32'h0,         4'd0, 1'b1, 1'b1, 32'h0,         1'b0, 2'd0, 1'b0, 8'd8},  // R8 B still draining
        '{2'd3, 1'b0, 16'h0000, 2'd1, 32'h0,         4'd0, 1'b0, 1'b0, 32'h0,         1'b0, 2'd0, 1'b0, 8'd7},  // R7 last ack B
        '{2'd1, 1'b1, 16'h0200, 2'd0, 32'h0,         4'd0, 1'b1, 1'b1, 32'h0,         1'b1, 2'd1, 1'b0, 8'd7},  // R7 slot 1 free again
        '{2'd1, 1'b0, 16'h0400, 2'd0, 32'h0,         4'd0, 1'b1, 1'b1, 32'h0,         1'b1, 2'd2, 1'b0, 8'd11}, // R11 D -> slot 2
        '{2'd1, 1'b0, 16'h0500, 2'd0, 32'h0,         4'd0, 1'b1, 1'b1, 32'h0,         1'b1, 2'd3, 1'b0, 8'd11}, // R11 E -> slot 3
        '{2'd1, 1'b0, 16'h0600, 2'd0, 32'h0,         4'd0, 1'b1, 1'b1, 32'h0,         1'b0, 2'd0, 1'b0, 8'd10}, // R10 table full
        '{2'd2, 1'b0, 16'h0000, 2'd2, 32'hCCCC0003, 4'd0, 1'b0, 1'b0, 32'h0,         1'b0, 2'd0, 1'b1, 8'd4},  // R4 reply D
        '{2'd1, 1'b0, 16'h0400, 2'd0, 32'h0,         4'd0, 1'b1, 1'b0, 32'hCCCC0003, 1'b0, 2'd0, 1'b0, 8'd6},  // R6 data D frees slot 2
        '{2'd1, 1'b0, 16'h0600, 2'd0, 32'h0,         4'd0, 1'b1, 1'b1, 32'h0,         1'b1, 2'd2, 1'b0, 8'd10}  // R10 F accepted
    };

    task automatic clear_inputs();
        cpu_req_valid = 1'b0;
        rep_valid     = 1'b0;
        ack_valid     = 1'b0;
    endtask

    task automatic check_vec(input vec_t v, input int k);
        logic bad;
        bad = 1'b0;
        if (cpu_rsp_valid !== v.e_rsp) bad = 1'b1;
        if (v.e_rsp && cpu_rsp_retry !== v.e_retry) bad = 1'b1;
        if (v.e_rsp && !v.e_retry && cpu_rsp_data !== v.e_data) bad = 1'b1;
        if (net_req_valid !== v.e_net) bad = 1'b1;
        if (v.e_net && (net_req_tag !== v.e_tag || net_req_excl !== v.excl
                        || net_req_addr !== v.addr)) bad = 1'b1;
        if (cpu_wake !== v.e_wake) bad = 1'b1;
        if (v.e_wake && cpu_wake_tag !== v.tag) bad = 1'b1;
        n_checks++;
        if (bad) begin
            n_fail++;
            $display("FAIL R%0d vector %0d: actual rsp=%b retry=%b data=%h net=%b tag=%0d excl=%b addr=%h wake=%b wtag=%0d; expected rsp=%b retry=%b data=%h net=%b tag=%0d wake=%b wtag=%0d",
                     v.rq, k, cpu_rsp_valid, cpu_rsp_retry, cpu_rsp_data, net_req_valid,
                     net_req_tag, net_req_excl, net_req_addr, cpu_wake, cpu_wake_tag,
                     v.e_rsp, v.e_retry, v.e_data, v.e_net, v.e_tag, v.e_wake, v.tag);
        end
    endtask

    task automatic check_idle(input string what);
        n_checks++;
        if (cpu_rsp_valid !== 1'b0 || net_req_valid !== 1'b0 || cpu_wake !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 %s: actual rsp=%b net=%b wake=%b; expected 0 0 0",
                     what, cpu_rsp_valid, net_req_valid, cpu_wake);
        end
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: run did not complete; expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_idle("outputs during reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("outputs after reset");  // R1

        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            case (VECS[k].kind)
                2'd1: begin
                    cpu_req_valid = 1'b1;
                    cpu_req_excl  = VECS[k].excl;
                    cpu_req_addr  = VECS[k].addr;
                end
                2'd2: begin
                    rep_valid   = 1'b1;
                    rep_tag     = VECS[k].tag;
                    rep_data    = VECS[k].data;
                    rep_inv_cnt = VECS[k].cnt;
                end
                2'd3: begin
                    ack_valid = 1'b1;
                    ack_tag   = VECS[k].tag;
                end
                default: ;
            endcase
            @(negedge clk);
            clear_inputs();
            check_vec(VECS[k], k);
        end

        // R1: mid-run reset drops every tracked slot
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check_idle("outputs during mid-run reset");
        rst_n = 1'b1;
        @(negedge clk);
        cpu_req_valid = 1'b1;
        cpu_req_excl  = 1'b0;
        cpu_req_addr  = 16'h0700;
        @(negedge clk);
        clear_inputs();
        n_checks++;
        if (net_req_valid !== 1'b1 || net_req_tag !== 2'd0 || cpu_rsp_retry !== 1'b1) begin
            n_fail++;
            $display("FAIL R1 after mid-run reset: actual net=%b tag=%0d retry=%b; expected net=1 tag=0 retry=1",
                     net_req_valid, net_req_tag, cpu_rsp_retry);
        end

        // R1: the old line is no longer tracked, so it is requested afresh
        @(negedge clk);
        cpu_req_valid = 1'b1;
        cpu_req_addr  = 16'h0500;
        @(negedge clk);
        clear_inputs();
        n_checks++;
        if (net_req_valid !== 1'b1 || net_req_tag !== 2'd1) begin
            n_fail++;
            $display("FAIL R1 stale line after reset: actual net=%b tag=%0d; expected net=1 tag=1",
                     net_req_valid, net_req_tag);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule